// File: doc/BRIEF.md
# Double-Buffered Converter Load Path

This block is the digital front end of an 8-bit voltage-output converter. A byte from a parallel bus is captured into a first (input) stage, then moved into a second (output) stage whose contents form the code handed to the converter core. The two stages share one active-low write strobe. Each stage also has its own active-low enable: chip select for the input stage and load for the output stage. Because of this, a new value can be staged while the old one is still driving the output, and then applied at a moment the system chooses. Driving all three strobes low makes both stages transparent, so the bus flows straight through to the output.

All controls act on level. Each stage is modelled as a clocked register that reloads on every cycle while its enable condition holds. The strobes and the data bus pass through a two-flop synchronizer first, so any change at the pins reaches the stored code on the third rising clock edge. An active-low clear empties both stages at once. If the stages are transparent, the clear only overrides the output for as long as it is held. If the stages are latched, the stored zeros remain after the clear is released. A flag tells the system when the output code is zero.

Top module: `dac_load_path`

## Requirements
- R1: The data path is 8 bits wide, with bit 7 as the most significant bit. `dacCode` carries the output stage bit for bit, and code N stands for N/256 of the reference.
- R2: A change on `csN`, `wrN`, `ldN` or `dataIn` has no effect on the stored stages until the third rising clock edge after the change. It takes effect at that edge.
- R3: The input stage reloads from the synchronized bus on every cycle in which synchronized `csN` and `wrN` are both low. Otherwise it holds its value.
- R4: The output stage reloads from the input stage on every cycle in which synchronized `ldN` and `wrN` are both low. Otherwise it holds its value.
- R5: When `csN`, `wrN` and `ldN` are all low, the output stage takes the bus value in the same cycle as the input stage does, so `dacCode` follows `dataIn`.
- R6: While `clrN` is low, both stages are zero, whatever the other inputs are.
- R7: If all strobes are low when `clrN` is released, `dacCode` returns to following `dataIn`.
- R8: If the stages are latched when `clrN` is pulsed low, `dacCode` stays at zero after the release, until a load takes place.
- R9: `zeroForced` is high exactly when `clrN` is low or `dacCode` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the level-sensitive controls |
| clrN | input | 1 | Active-low clear of both stages (asynchronous) |
| csN | input | 1 | Active-low chip select, enables the input stage |
| wrN | input | 1 | Active-low write strobe, shared by both stages |
| ldN | input | 1 | Active-low load, enables the output stage |
| dataIn | input | 8 | Parallel data bus, bit 7 is the MSB |
| dacCode | output | 8 | Code held in the output stage |
| zeroForced | output | 1 | High while the output code is zero or the clear is held |

## Verification
The hardest case to reach is the difference between a clear applied to transparent stages and a clear applied to latched stages. Both cases look the same while `clrN` is low and only differ after the release. The bench therefore loads a nonzero value and then pulses `clrN`, once with all strobes held low and once with them held high. In each case it samples `dacCode` several cycles after the release. The contents of the input stage cannot be seen directly, so the bench exposes them by running a later transfer with chip select high and comparing `dacCode` against its own model.

// File: rtl/dac_load_pkg.sv
package dac_load_pkg;
  typedef struct packed {
    logic inLoad;   // input stage reloads this cycle
    logic dacLoad;  // output stage reloads this cycle
  } loadStrobes_t;
endpackage

// File: rtl/dac_load_ctrl.sv
module dac_load_ctrl
  import dac_load_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              ldN,
  input  logic [DATA_W-1:0] dataIn,
  output loadStrobes_t      strobes,
  output logic [DATA_W-1:0] dataSync
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] csPipe, wrPipe, ldPipe;
  logic [DATA_W-1:0]      dataPipe [SYNC_STAGES];

  // Controls reset to their inactive (high) level
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      csPipe <= '1;
      wrPipe <= '1;
      ldPipe <= '1;
    end else begin
      csPipe <= {csPipe[SYNC_STAGES-2:0], csN};
      wrPipe <= {wrPipe[SYNC_STAGES-2:0], wrN};
      ldPipe <= {ldPipe[SYNC_STAGES-2:0], ldN};
    end
  end

  // Data travels through the same depth so it stays aligned with the strobes
  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gDataSync
      always_ff @(posedge clk or negedge clrN) begin
        if (!clrN)       dataPipe[g] <= '0;
        else if (g == 0) dataPipe[g] <= dataIn;
        else             dataPipe[g] <= dataPipe[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  always_comb begin
    strobes.inLoad  = !csPipe[LAST] && !wrPipe[LAST];
    strobes.dacLoad = !ldPipe[LAST] && !wrPipe[LAST];
    dataSync        = dataPipe[LAST];
  end
endmodule

// File: rtl/dac_load_regs.sv
module dac_load_regs
  import dac_load_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              clrN,
  input  loadStrobes_t      strobes,
  input  logic [DATA_W-1:0] dataSync,
  output logic [DATA_W-1:0] dacCode,
  output logic              zeroForced
);
  logic [DATA_W-1:0] inReg, dacReg;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)               inReg <= '0;
    else if (strobes.inLoad) inReg <= dataSync;
  end

  // With both stages open the bus flows through in the same cycle
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN)                dacReg <= '0;
    else if (strobes.dacLoad) dacReg <= strobes.inLoad ? dataSync : inReg;
  end

  assign dacCode    = dacReg;
  assign zeroForced = !clrN || (dacReg == '0);

  // R3
  in_hold_chk: assert property (@(posedge clk) disable iff (!clrN)
    !strobes.inLoad |=> $stable(inReg));
  // R4
  dac_hold_chk: assert property (@(posedge clk) disable iff (!clrN)
    !strobes.dacLoad |=> $stable(dacReg));
  // R4
  dac_xfer_chk: assert property (@(posedge clk) disable iff (!clrN)
    (strobes.dacLoad && !strobes.inLoad) |=> (dacReg == $past(inReg)));
  // R5
  flow_through_chk: assert property (@(posedge clk) disable iff (!clrN)
    (strobes.dacLoad && strobes.inLoad) |=> (dacReg == $past(dataSync)));
  // R6
  clear_zero_chk: assert property (@(negedge clk)
    !clrN |-> (dacReg == '0 && inReg == '0 && zeroForced));
endmodule

// File: rtl/dac_load_path.sv
module dac_load_path
  import dac_load_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              clrN,
  input  logic              csN,
  input  logic              wrN,
  input  logic              ldN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dacCode,
  output logic              zeroForced
);
  loadStrobes_t      strobes;
  logic [DATA_W-1:0] dataSync;

  dac_load_ctrl #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .clrN(clrN), .csN(csN), .wrN(wrN), .ldN(ldN),
    .dataIn(dataIn), .strobes(strobes), .dataSync(dataSync)
  );

  dac_load_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .clrN(clrN), .strobes(strobes), .dataSync(dataSync),
    .dacCode(dacCode), .zeroForced(zeroForced)
  );
endmodule

// File: tb/dac_load_path_tb.sv
module dac_load_path_tb;
  logic       clk = 1'b0;
  logic       clrN = 1'b0;
  logic       csN = 1'b1, wrN = 1'b1, ldN = 1'b1;
  logic [7:0] dataIn = 8'h00;
  logic [7:0] dacCode;
  logic       zeroForced;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] mIn = 8'h00, mDac = 8'h00;

  always #2.5 clk = ~clk;

  dac_load_path u_dut (
    .clk(clk), .clrN(clrN), .csN(csN), .wrN(wrN), .ldN(ldN),
    .dataIn(dataIn), .dacCode(dacCode), .zeroForced(zeroForced)
  );

  task automatic check(input string req, input logic [7:0] exp);
    logic expZ;
    expZ = !clrN || (exp == 8'h00);
    nChecks++;
    if (dacCode !== exp) begin
      nFails++;
      $display("FAIL %s dacCode actual=%02h expected=%02h", req, dacCode, exp);
    end
    nChecks++;
    if (zeroForced !== expZ) begin
      nFails++;
      $display("FAIL R9 (%s) zeroForced actual=%0b expected=%0b", req, zeroForced, expZ);
    end
  endtask

  // Drive at a falling edge, settle, update model, compare
  task automatic step(input logic c, input logic w, input logic l,
                      input logic [7:0] d, input string req);
    logic [7:0] oldIn;
    @(negedge clk);
    csN = c; wrN = w; ldN = l; dataIn = d;
    repeat (4) @(negedge clk);
    oldIn = mIn;
    if (!clrN) begin
      mIn = 8'h00; mDac = 8'h00;
    end else begin
      if (!c && !w) mIn = d;
      if (!l && !w) mDac = (!c) ? d : oldIn;
    end
    check(req, mDac);
  endtask

  task automatic t_reset();
    check("R6 reset state", 8'h00);
  endtask

  task automatic t_latency();
    @(negedge clk);
    csN = 0; wrN = 0; ldN = 0; dataIn = 8'hA5;
    @(negedge clk); @(negedge clk);
    check("R2 before third edge", mDac);
    @(negedge clk);
    mIn = 8'hA5; mDac = 8'hA5;
    check("R2 at third edge", 8'hA5);
    step(1, 1, 1, 8'h00, "R2 settle latched");
  endtask

  task automatic t_stage();
    step(0, 0, 1, 8'h3C, "R3 input stage only");
    step(1, 0, 1, 8'hFF, "R3 cs high holds");
    step(1, 0, 0, 8'h11, "R4 transfer to output");
    step(0, 1, 0, 8'h77, "R4 wr high holds");
    step(0, 0, 1, 8'h80, "R3 stage 80");
    step(1, 1, 0, 8'h00, "R4 wr high no transfer");
    step(1, 0, 0, 8'h00, "R1 msb transfer");
    step(0, 0, 1, 8'h01, "R3 stage 01");
    step(1, 0, 0, 8'hEE, "R1 lsb transfer");
  endtask

  task automatic t_flow();
    for (int i = 0; i < 4; i++)
      step(0, 0, 0, 8'(8'h5A + 8'(i * 37)), "R5 flow-through");
    step(0, 0, 0, 8'hFF, "R5 full scale");
  endtask

  task automatic t_clrTransparent();
    step(0, 0, 0, 8'hC3, "R5 before clear");
    @(negedge clk); clrN = 0;
    @(negedge clk);
    mIn = 8'h00; mDac = 8'h00;
    check("R6 clear while transparent", 8'h00);
    step(0, 0, 0, 8'hC3, "R6 held clear ignores bus");
    @(negedge clk); clrN = 1;
    repeat (4) @(negedge clk);
    mIn = 8'hC3; mDac = 8'hC3;
    check("R7 follows bus after release", 8'hC3);
  endtask

  task automatic t_clrLatched();
    step(0, 0, 0, 8'h9D, "R5 load before latched clear");
    step(1, 1, 1, 8'h44, "R3 latched");
    @(negedge clk); clrN = 0;
    @(negedge clk);
    mIn = 8'h00; mDac = 8'h00;
    check("R6 clear while latched", 8'h00);
    @(negedge clk); clrN = 1;
    repeat (6) @(negedge clk);
    check("R8 stays zero after release", 8'h00);
    step(1, 0, 0, 8'h44, "R8 input stage was cleared");
  endtask

  initial begin
    #1000000;
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    clrN = 1;
    repeat (3) @(negedge clk);
    t_latency();
    t_stage();
    t_flow();
    t_clrTransparent();
    t_clrLatched();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule